// File: doc/BRIEF.md
# Prefixed Rotate Execution Unit

This block carries out the four byte-rotate operations found on the prefixed bit-operation page of an 8-bit processor. A controller hands it an opcode together with a one-cycle start strobe. The unit works out two things from the opcode: which operand to use and which rotation to apply. It reads the operand from the register file bus or from memory, computes the rotated byte and the new flag byte, and drives write strobes back to the register file, the flag register or memory. Done pulses once, in the final clock of the operation.

Seven general registers arrive on one packed bus, one byte per operand code. Operand code 6 does not select a register. It selects the byte in memory addressed by the H:L pair, using a synchronous memory with one clock of read latency, so that form needs a read-modify-write sequence and twice as many machine cycles. A machine cycle lasts `MCYC_CLKS` clocks.

Top module: `rot_unit`

## Requirements
- R1: Opcode bits [2:0] pick the operand: 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 7=A, each being the byte at that index of `regs_in`. Code 6 picks memory. For a register operand the result is written with `reg_sel` equal to that code.
- R2: Opcode bits [4:3] pick the rotation: 0 circular left, 1 circular right, 2 left through carry, 3 right through carry.
- R3: A circular left rotation moves bit 7 to bit 0 and sets C to the old bit 7. A circular right rotation moves bit 0 to bit 7 and sets C to the old bit 0.
- R4: A left rotation through carry puts the incoming C (`flags_in` bit 4 at start) into bit 0 and sets C to the old bit 7. A right rotation through carry puts the incoming C into bit 7 and sets C to the old bit 0.
- R5: The flag byte written is Z at bit 7, N at bit 6, H at bit 5, C at bit 4, with bits [3:0] zero. N and H are always cleared. Z is 1 exactly when the written result is zero.
- R6: For a register operand, done is high for one clock, 2*MCYC_CLKS clocks after the clock edge that accepts start. The register and flag write strobes are high only in that clock.
- R7: For the memory operand, done comes 4*MCYC_CLKS clocks after acceptance. `mem_re` is high for one clock, MCYC_CLKS clocks after acceptance. The byte is written back with `mem_we` for exactly one clock, in the done clock. Both accesses use the H:L value captured at start.
- R8: A start while the unit is busy is ignored. The operation in flight keeps its timing and its result.
- R9: An opcode above 0x1F is unsupported. It writes nothing, finishes after 2*MCYC_CLKS clocks, and raises `unsup` together with done.
- R10: While reset is held, the unit is idle and no strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| opcode | input | 8 | Prefixed-page opcode |
| regs_in | input | 64 | Register bytes, byte k at bits [8k+7:8k], indexed by operand code |
| flags_in | input | 8 | Current flag byte, C at bit 4 |
| done | output | 1 | Final clock of the operation |
| unsup | output | 1 | Unsupported opcode, valid with done |
| reg_we | output | 1 | Register write strobe |
| reg_sel | output | 3 | Register index to write |
| reg_wdata | output | 8 | Register write data |
| flag_we | output | 1 | Flag register write strobe |
| flag_wdata | output | 8 | New flag byte |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address (H:L captured at start) |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one clock after mem_re |

## Verification
The bench builds the unit with MCYC_CLKS = 2, so a register form takes 4 clocks and the memory form takes 8. At that setting the read strobe, the data capture and the write-back fall on consecutive or nearly consecutive clocks, which is where an off-by-one in the memory sequencing shows up. The short latency also lets every one of the 32 supported opcodes run, along with several carry-sensitive zero cases, back-to-back chained rotations, starts issued mid-operation and unsupported opcodes, all well inside the cycle budget.

// File: rtl/rot_pkg.sv
// Shared types and constants for the rotate execution unit.
// Assumes an 8-bit data path and the flag layout Z/N/H/C in bits 7..4.
package rot_pkg;
    localparam int BYTE_W   = 8;
    localparam int NREG     = 8;
    localparam int SEL_W    = $clog2(NREG);
    localparam int ADDR_W   = 2 * BYTE_W;

    localparam logic [SEL_W-1:0] SRC_MEM = 3'd6;
    localparam int IDX_H = 4;
    localparam int IDX_L = 5;

    localparam int FLG_Z = 7;
    localparam int FLG_N = 6;
    localparam int FLG_H = 5;
    localparam int FLG_C = 4;

    typedef enum logic [1:0] {
        ROT_LC = 2'd0,
        ROT_RC = 2'd1,
        ROT_LT = 2'd2,
        ROT_RT = 2'd3
    } rot_kind_e;

    typedef struct packed {
        rot_kind_e        kind;
        logic [SEL_W-1:0] src;
        logic             is_mem;
        logic             illegal;
    } rot_cmd_t;
endpackage

// File: rtl/rot_decode.sv
// Opcode decoder: splits the opcode into operation kind and operand source,
// and marks opcodes outside the rotate group as illegal.
// Assumes the rotate group occupies opcodes whose top three bits are zero.
module rot_decode
    import rot_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output rot_cmd_t          cmd
);
    // Purely combinational field extraction.
    always_comb begin
        cmd.kind    = rot_kind_e'(opcode[4:3]);
        cmd.src     = opcode[2:0];
        cmd.illegal = (opcode[7:5] != 3'd0);
        cmd.is_mem  = (opcode[2:0] == SRC_MEM) && (opcode[7:5] == 3'd0);
    end
endmodule

// File: rtl/rot_alu.sv
// Rotate datapath: computes the rotated byte and the resulting flag byte.
// Assumes cin is the carry flag value captured when the operation began.
module rot_alu
    import rot_pkg::*;
(
    input  logic [BYTE_W-1:0] val,
    input  logic              cin,
    input  rot_kind_e         kind,
    output logic [BYTE_W-1:0] res,
    output logic [BYTE_W-1:0] flags
);
    logic cout;

    // Select the bit that fills the vacated position and the bit shifted out.
    always_comb begin
        unique case (kind)
            ROT_LC: begin res = {val[BYTE_W-2:0], val[BYTE_W-1]}; cout = val[BYTE_W-1]; end
            ROT_RC: begin res = {val[0], val[BYTE_W-1:1]};        cout = val[0];        end
            ROT_LT: begin res = {val[BYTE_W-2:0], cin};           cout = val[BYTE_W-1]; end
            default: begin res = {cin, val[BYTE_W-1:1]};          cout = val[0];        end
        endcase
    end

    // Assemble the flag byte; N and H always clear, low nibble always zero.
    always_comb begin
        flags        = '0;
        flags[FLG_Z] = (res == '0);
        flags[FLG_C] = cout;
    end
endmodule

// File: rtl/rot_seq.sv
// Machine-cycle sequencer: counts clocks of one operation, flags the memory
// read slot and the final clock. Assumes MCYC_CLKS >= 1.
module rot_seq #(
    parameter int MCYC_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic long_op,
    output logic busy,
    output logic accept,
    output logic rd_pulse,
    output logic last
);
    localparam int REG_CLKS = 2 * MCYC_CLKS;
    localparam int MEM_CLKS = 4 * MCYC_CLKS;
    localparam int CNT_W    = $clog2(MEM_CLKS);
    localparam logic [CNT_W-1:0] LAST_REG = CNT_W'(REG_CLKS - 1);
    localparam logic [CNT_W-1:0] LAST_MEM = CNT_W'(MEM_CLKS - 1);
    localparam logic [CNT_W-1:0] RD_AT    = CNT_W'(MCYC_CLKS);

    logic [CNT_W-1:0] cnt;
    logic             long_q;

    assign accept   = start && !busy;
    assign last     = busy && (cnt == (long_q ? LAST_MEM : LAST_REG));
    assign rd_pulse = busy && long_q && (cnt == RD_AT);

    // Track the clock position within the current operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            long_q <= 1'b0;
        end else if (accept) begin
            busy   <= 1'b1;
            cnt    <= '0;
            long_q <= long_op;
        end else if (last) begin
            busy   <= 1'b0;
        end else if (busy) begin
            cnt    <= cnt + CNT_W'(1);
        end
    end

    // R8: an operation in flight keeps counting regardless of start.
    a_r8_busy_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> (busy && cnt == $past(cnt) + CNT_W'(1)));

    // R6: the unit returns to idle right after the final clock.
    a_r6_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !busy);

    // R10: reset forces the idle state.
    a_r10_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && cnt == '0));
endmodule

// File: rtl/rot_unit.sv
// Rotate execution unit top: latches the command and operand on start,
// sequences a register or memory read-modify-write operation, and drives
// write strobes in the final clock. Assumes the memory returns read data
// one clock after mem_re and that the register file applies writes on the
// clock edge that ends the done cycle.
module rot_unit
    import rot_pkg::*;
#(
    parameter int MCYC_CLKS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [BYTE_W-1:0]       opcode,
    input  logic [NREG*BYTE_W-1:0]  regs_in,
    input  logic [BYTE_W-1:0]       flags_in,
    output logic                    done,
    output logic                    unsup,
    output logic                    reg_we,
    output logic [SEL_W-1:0]        reg_sel,
    output logic [BYTE_W-1:0]       reg_wdata,
    output logic                    flag_we,
    output logic [BYTE_W-1:0]       flag_wdata,
    output logic                    mem_re,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [BYTE_W-1:0]       mem_wdata,
    input  logic [BYTE_W-1:0]       mem_rdata
);
    logic [BYTE_W-1:0] reg_arr [NREG];
    rot_cmd_t          cmd_d, cmd_q;
    logic              busy, accept, rd_pulse, last;
    logic              rd_d;
    logic [BYTE_W-1:0] opnd_q;
    logic              carry_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] alu_res, alu_flags;
    logic              unused_flag_bits;

    // Unpack the register bus, one byte per operand code.
    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign reg_arr[g] = regs_in[g*BYTE_W +: BYTE_W];
    end

    assign unused_flag_bits = ^{flags_in[BYTE_W-1:FLG_C+1], flags_in[FLG_C-1:0]};

    rot_decode u_dec (
        .opcode (opcode),
        .cmd    (cmd_d)
    );

    rot_seq #(.MCYC_CLKS(MCYC_CLKS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .long_op  (cmd_d.is_mem),
        .busy     (busy),
        .accept   (accept),
        .rd_pulse (rd_pulse),
        .last     (last)
    );

    // Capture command, operand, carry and address at start; load memory data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            opnd_q  <= '0;
            carry_q <= 1'b0;
            addr_q  <= '0;
            rd_d    <= 1'b0;
        end else begin
            rd_d <= rd_pulse;
            if (accept) begin
                cmd_q   <= cmd_d;
                opnd_q  <= reg_arr[cmd_d.src];
                carry_q <= flags_in[FLG_C];
                addr_q  <= {reg_arr[IDX_H], reg_arr[IDX_L]};
            end else if (rd_d) begin
                opnd_q  <= mem_rdata;
            end
        end
    end

    rot_alu u_alu (
        .val   (opnd_q),
        .cin   (carry_q),
        .kind  (cmd_q.kind),
        .res   (alu_res),
        .flags (alu_flags)
    );

    // Drive completion and write strobes in the final clock only.
    always_comb begin
        done       = last;
        unsup      = last && cmd_q.illegal;
        reg_we     = last && !cmd_q.illegal && !cmd_q.is_mem;
        flag_we    = last && !cmd_q.illegal;
        mem_we     = last && cmd_q.is_mem;
        mem_re     = rd_pulse;
        reg_sel    = cmd_q.src;
        reg_wdata  = alu_res;
        flag_wdata = alu_flags;
        mem_wdata  = alu_res;
        mem_addr   = addr_q;
    end

    // R7: the memory write strobe never lasts beyond one clock.
    a_r7_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R7: the address presented at the read is still there afterwards.
    a_r7_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> $stable(mem_addr));

    // R5: written flag byte has N, H and the low nibble clear.
    a_r5_flag_shape: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> (flag_wdata[3:0] == 4'd0 && !flag_wdata[FLG_N] && !flag_wdata[FLG_H]));

    // R9: an unsupported opcode completes with no write strobe.
    a_r9_unsup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        unsup |-> !(reg_we || flag_we || mem_we));

    // R6: a single-clock done pulse.
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/sim_rot_unit.sv
// Bench for rot_unit: behavioural register file, memory and reference model,
// compared against the outputs at every falling clock edge.
module sim_rot_unit;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int MC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [63:0] regs_bus;
    logic [7:0]  fl;
    logic [7:0]  rf [0:7];
    logic [7:0]  mem [0:255];
    logic [7:0]  mem_rdata;

    logic        pre_en = 1'b0;
    logic [3:0]  pre_sel = 4'd0;
    logic [7:0]  pre_val = 8'h00;
    logic [7:0]  pre_addr = 8'h00;

    logic        done, unsup, reg_we, flag_we, mem_re, mem_we;
    logic [2:0]  reg_sel;
    logic [7:0]  reg_wdata, flag_wdata, mem_wdata;
    logic [15:0] mem_addr;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 8; i++) regs_bus[i*8 +: 8] = rf[i];
    end

    rot_unit #(.MCYC_CLKS(MC)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .regs_in(regs_bus), .flags_in(fl),
        .done(done), .unsup(unsup),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .flag_we(flag_we), .flag_wdata(flag_wdata),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Register file, flag register and synchronous memory around the unit.
    always @(posedge clk) begin
        if (pre_en) begin
            if (pre_sel < 4'd8)       rf[pre_sel[2:0]] <= pre_val;
            else if (pre_sel == 4'd8) fl <= pre_val;
            else                      mem[pre_addr] <= pre_val;
        end
        if (reg_we)  rf[reg_sel] <= reg_wdata;
        if (flag_we) fl <= flag_wdata;
        if (mem_we)  mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re)  mem_rdata <= mem[mem_addr[7:0]];
    end

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    bit        m_busy = 1'b0;
    int        m_cnt, m_total, m_kind;
    bit        m_mem, m_ill;
    int        m_sel, m_res, m_flags, m_addr;

    task automatic chk(input string tag, input string what, input int got, input int exp);
        compared++;
        if (got != exp) begin
            mismatched++;
            $display("FAIL %s %s: got %0h expected %0h (cycle %0d)", tag, what, got, exp, cyc);
        end
    endtask

    function automatic void model_start(input int op);
        int v, c, r, co;
        m_ill   = (op > 31);
        m_sel   = op % 8;
        m_kind  = (op / 8) % 4;
        m_mem   = !m_ill && (m_sel == 6);
        m_total = (m_mem ? 4 : 2) * MC;
        m_cnt   = 0;
        m_busy  = 1'b1;
        m_addr  = rf[4] * 256 + rf[5];
        v = m_mem ? int'(mem[m_addr % 256]) : int'(rf[m_sel]);
        c = fl[4] ? 1 : 0;
        case (m_kind)
            0: begin r = ((v * 2) % 256) + v / 128; co = v / 128; end
            1: begin r = v / 2 + (v % 2) * 128;     co = v % 2;   end
            2: begin r = ((v * 2) % 256) + c;       co = v / 128; end
            default: begin r = v / 2 + c * 128;     co = v % 2;   end
        endcase
        m_res   = r;
        m_flags = (r == 0 ? 128 : 0) + co * 16;
    endfunction

    // Reference model advance and comparison on every falling edge.
    always @(negedge clk) begin
        bit e_done, e_re;
        string dtag;
        cyc++;
        if (!rst_n) m_busy = 1'b0;
        else if (m_busy) begin
            if (m_cnt == m_total - 1) m_busy = 1'b0;
            else m_cnt++;
        end else if (start) model_start(int'(opcode));

        if (rst_n) begin
            e_done = m_busy && (m_cnt == m_total - 1);
            e_re   = m_busy && m_mem && (m_cnt == MC);
            dtag   = (m_kind < 2) ? "R2,R3" : "R2,R4";
            chk("R6,R8", "done",    done,    e_done);
            chk("R9",    "unsup",   unsup,   e_done && m_ill);
            chk("R1",    "reg_we",  reg_we,  e_done && !m_ill && !m_mem);
            chk("R5",    "flag_we", flag_we, e_done && !m_ill);
            chk("R7",    "mem_we",  mem_we,  e_done && m_mem);
            chk("R7",    "mem_re",  mem_re,  e_re);
            if (e_done && !m_ill && !m_mem) begin
                chk("R1", "reg_sel",   reg_sel,   m_sel);
                chk(dtag, "reg_wdata", reg_wdata, m_res);
            end
            if (e_done && !m_ill) chk("R5", "flag_wdata", flag_wdata, m_flags);
            if (e_done && m_mem) begin
                chk("R7", "write addr", mem_addr,  m_addr);
                chk(dtag, "mem_wdata",  mem_wdata, m_res);
            end
            if (e_re) chk("R7", "read addr", mem_addr, m_addr);
        end

        if (cyc > 20000) begin
            mismatched++;
            $display("FAIL R6 watchdog expired: got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic preload(input int sel, input logic [7:0] val, input logic [7:0] addr);
        @(negedge clk); #0.5;
        pre_en = 1'b1; pre_sel = 4'(sel); pre_val = val; pre_addr = addr;
        @(negedge clk); #0.5;
        pre_en = 1'b0;
    endtask

    task automatic run(input logic [7:0] op, input bit poke);
        @(negedge clk); #0.5;
        start = 1'b1; opcode = op;
        @(negedge clk); #0.5;
        start = 1'b0; opcode = 8'hAA;
        if (poke) begin
            // R8: a second start in the middle of the operation
            @(negedge clk); #0.5;
            start = 1'b1; opcode = 8'h07;
            @(negedge clk); #0.5;
            start = 1'b0;
        end
        do begin
            @(negedge clk); #0.5;
        end while (m_busy);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #0.5;
        // R10: quiet outputs while reset is held
        chk("R10", "done in reset",   done,   0);
        chk("R10", "reg_we in reset", reg_we, 0);
        chk("R10", "mem_we in reset", mem_we, 0);
        chk("R10", "mem_re in reset", mem_re, 0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R6 R7: every supported opcode once
        for (int op = 0; op < 32; op++) begin
            logic [7:0] v;
            v = 8'((op * 53 + 29) % 256);
            preload(8, (op % 3 == 0) ? 8'h1F : 8'h0F, 8'h00);
            preload(4, 8'h12, 8'h00);
            preload(5, 8'h34, 8'h00);
            if (op % 8 == 6) preload(9, v, 8'h34);
            else             preload(op % 8, v, 8'h00);
            run(8'(op), (op == 9) || (op == 22));
        end

        // R4 R5: zero input with carry set yields one, Z clear
        preload(7, 8'h00, 8'h00); preload(8, 8'h10, 8'h00);
        run(8'h17, 1'b0);
        // R4 R5: right through carry of 0x01, carry clear, gives zero
        preload(7, 8'h01, 8'h00); preload(8, 8'h00, 8'h00);
        run(8'h1F, 1'b0);
        // R3 R5: circular left of zero
        preload(0, 8'h00, 8'h00); preload(8, 8'h10, 8'h00);
        run(8'h00, 1'b0);
        // R3 R7: circular right of memory 0x01 at 0x12:0x34
        preload(4, 8'h12, 8'h00); preload(5, 8'h34, 8'h00);
        preload(9, 8'h01, 8'h34);
        run(8'h0E, 1'b1);
        // R4: chained left rotations through carry of A
        preload(7, 8'h81, 8'h00); preload(8, 8'h00, 8'h00);
        for (int k = 0; k < 9; k++) run(8'h17, 1'b0);
        // R7: repeated memory rotation reuses the written byte
        for (int k = 0; k < 3; k++) run(8'h1E, 1'b0);

        // R9: unsupported opcodes, including one with the memory operand code
        run(8'h20, 1'b0);
        run(8'h26, 1'b0);
        run(8'h46, 1'b1);
        run(8'hFF, 1'b0);
        // state still intact: next operation reads the unchanged A and flags
        run(8'h0F, 1'b0);

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule